// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central bookkeeper for an out-of-order execution core built from five multi-cycle functional units (one integer unit, two multipliers, one adder, one divider) that share a 32-entry register file. A decoded instruction is presented at the head of the fetch buffer as a unit kind, a destination register and two source registers. The controller decides when that instruction may leave the buffer, when its unit may read its operands from the register file, and when the unit's finished result may be written back.

Each hazard class has its own gate. A structural conflict (no idle unit of the required kind) or an output conflict (another in-flight instruction already targets the same destination) holds the head of the buffer, and nothing behind it can pass. A true data dependence delays only the operand read of the dependent unit, so independent work can start executing ahead of it. An anti-dependence delays only the write of the completing unit. No operand forwarding exists: a value becomes readable in the cycle after its write grant.

The controller keeps one status entry per unit (state, kind, destination, sources, producing unit of each source and a ready flag for each source) and one producer tag per register. When several units request a read grant or a write grant in the same cycle, the lowest unit index wins.

Top module: `scoreboard_ctl`

## Requirements
- R1: After reset every unit is idle, no register has a pending writer, read_grant and write_grant are all zero, and in_ready is high for any kind and destination.
- R2: Unit kind codes are 0 integer, 1 multiply, 2 add, 3 divide; unit index 0 is integer, 1 and 2 are multipliers, 3 is the adder, 4 is the divider. in_ready is low whenever no idle unit of the presented kind exists.
- R3: in_ready is low whenever any busy unit's destination register equals in_dst.
- R4: In a cycle with in_valid and in_ready both high, issue_unit is one-hot on the lowest-index idle unit of the presented kind; otherwise issue_unit is zero.
- R5: A unit receives read_grant only after every unit that was busy at its issue with a destination equal to one of its sources has received write_grant in a strictly earlier cycle; with no such producer, the read may be granted in the cycle after issue.
- R6: At most one read_grant bit is high per cycle, and it goes to the lowest-index unit whose operands are ready.
- R7: A done_pulse bit counts only for a unit that received read_grant in an earlier cycle and has not yet completed; at any other time it is ignored.
- R8: write_grant to a completed unit is withheld while any instruction issued before it has not yet received its read grant and names that unit's destination register as a source.
- R9: At most one write_grant bit is high per cycle, on the lowest-index completed unit free of the condition in R8; the earliest write grant is the cycle after the accepted done_pulse.
- R10: After write_grant a unit is idle and its destination register free, so a new instruction may use both from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented at the buffer head |
| in_kind | input | 2 | Required unit kind of the presented instruction |
| in_dst | input | 5 | Destination register |
| in_src_a | input | 5 | First source register |
| in_src_b | input | 5 | Second source register |
| in_ready | output | 1 | The presented instruction may issue this cycle |
| issue_unit | output | 5 | One-hot unit receiving the instruction this cycle |
| done_pulse | input | 5 | Per-unit pulse: execution result is ready |
| read_grant | output | 5 | Per-unit permission to read operands and start |
| write_grant | output | 5 | Per-unit permission to write its result |

## Verification
The bench goes after the classic three-instruction pattern in which a long divide feeds an add that also reads a register a later integer instruction overwrites; a design without the anti-dependence hold would let the integer result land before the add reads, and one with an over-broad hold would stall writes that do not conflict. It also targets a producer's write and its consumer's read meeting in the same cycle (a controller that forwarded or checked the ready flag too late would grant the read one cycle early), completion pulses aimed at idle or still-waiting units (which a careless design would turn into spurious write grants), and the third multiply or a repeated destination that must stall issue rather than overwrite a busy entry. Long random runs over a small register range keep many dependences alive at once so that arbitration ties between units are exercised in both grant paths.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_FU   = 5;
    localparam int NUM_REGS = 32;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int FU_W     = $clog2(NUM_FU);

    typedef enum logic [1:0] {
        K_INT = 2'd0,
        K_MUL = 2'd1,
        K_ADD = 2'd2,
        K_DIV = 2'd3
    } fu_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPWAIT = 2'd1,
        ST_EXEC   = 2'd2,
        ST_DONE   = 2'd3
    } fu_state_e;

    // Tag naming the unit that will produce a register value.
    typedef struct packed {
        logic            vld;
        logic [FU_W-1:0] idx;
    } producer_t;

    typedef struct packed {
        fu_state_e        state;
        fu_kind_e         kind;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        producer_t        prod_a;
        producer_t        prod_b;
        logic             rdy_a;
        logic             rdy_b;
    } fu_entry_t;

    // Fixed assignment of unit indices to kinds.
    function automatic fu_kind_e unit_kind(int unsigned idx);
        case (idx)
            0:       return K_INT;
            1, 2:    return K_MUL;
            3:       return K_ADD;
            default: return K_DIV;
        endcase
    endfunction

    function automatic logic [FU_W-1:0] oh_to_idx(logic [NUM_FU-1:0] oh);
        logic [FU_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (oh[i]) r = r | i[FU_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/sb_prio_arb.sv
module sb_prio_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Lowest set bit wins.
    assign gnt = req & (~req + N'(1));

    // R6 / R9 (and R4 when used for unit selection): single grant, only to a requester.
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    p_grant_when_req_r9: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> ($countones(gnt) == 1));

endmodule

// File: rtl/sb_unit_pick.sv
module sb_unit_pick
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fu_kind_e          kind,
    input  logic [NUM_FU-1:0] busy,
    output logic              found,
    output logic [NUM_FU-1:0] pick_oh
);

    logic [NUM_FU-1:0] cand;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_cand
        assign cand[u] = !busy[u] && (unit_kind(u) == kind);
    end

    assign found = |cand;

    sb_prio_arb #(.N(NUM_FU)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (cand),
        .gnt (pick_oh)
    );

endmodule

// File: rtl/sb_hazard_eval.sv
module sb_hazard_eval
    import sb_pkg::*;
(
    input  fu_entry_t [NUM_FU-1:0] tbl,
    output logic      [NUM_FU-1:0] rd_req,
    output logic      [NUM_FU-1:0] wr_req
);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        logic [NUM_FU-1:0] war_hit;

        // An unread peer whose ready source names our destination still needs the old value.
        for (genvar v = 0; v < NUM_FU; v++) begin : g_peer
            if (v == u) begin : g_self
                assign war_hit[v] = 1'b0;
            end else begin : g_other
                assign war_hit[v] = (tbl[v].state == ST_OPWAIT) &&
                    ((tbl[v].rdy_a && (tbl[v].src_a == tbl[u].dst)) ||
                     (tbl[v].rdy_b && (tbl[v].src_b == tbl[u].dst)));
            end
        end

        assign rd_req[u] = (tbl[u].state == ST_OPWAIT) && tbl[u].rdy_a && tbl[u].rdy_b;
        assign wr_req[u] = (tbl[u].state == ST_DONE) && !(|war_hit);
    end

endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src_a,
    input  logic [REG_W-1:0]  in_src_b,
    output logic              in_ready,
    output logic [NUM_FU-1:0] issue_unit,
    input  logic [NUM_FU-1:0] done_pulse,
    output logic [NUM_FU-1:0] read_grant,
    output logic [NUM_FU-1:0] write_grant
);

    fu_entry_t [NUM_FU-1:0]   tbl, tbl_nx;
    producer_t [NUM_REGS-1:0] res_stat, res_nx;

    logic [NUM_FU-1:0] busy, pick_oh, rd_req, wr_req;
    logic              found, issue_fire, wr_any;
    logic [FU_W-1:0]   pick_idx, wr_idx;
    producer_t         new_pa, new_pb;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_busy
        assign busy[u] = (tbl[u].state != ST_IDLE);
    end

    sb_unit_pick u_pick (
        .clk     (clk),
        .rst     (rst),
        .kind    (fu_kind_e'(in_kind)),
        .busy    (busy),
        .found   (found),
        .pick_oh (pick_oh)
    );

    sb_hazard_eval u_haz (
        .tbl    (tbl),
        .rd_req (rd_req),
        .wr_req (wr_req)
    );

    sb_prio_arb #(.N(NUM_FU)) u_rd_arb (
        .clk (clk),
        .rst (rst),
        .req (rd_req),
        .gnt (read_grant)
    );

    sb_prio_arb #(.N(NUM_FU)) u_wr_arb (
        .clk (clk),
        .rst (rst),
        .req (wr_req),
        .gnt (write_grant)
    );

    // Structural and output-dependence gate at the buffer head.
    assign in_ready   = found && !res_stat[in_dst].vld;
    assign issue_fire = in_valid && in_ready;
    assign issue_unit = issue_fire ? pick_oh : '0;
    assign pick_idx   = oh_to_idx(pick_oh);
    assign wr_any     = |write_grant;
    assign wr_idx     = oh_to_idx(write_grant);

    // Producer tags for the new entry; a producer writing this cycle is already resolved.
    always_comb begin
        new_pa = res_stat[in_src_a];
        new_pb = res_stat[in_src_b];
        if (wr_any && new_pa.vld && (new_pa.idx == wr_idx)) new_pa = '0;
        if (wr_any && new_pb.vld && (new_pb.idx == wr_idx)) new_pb = '0;
    end

    always_comb begin
        tbl_nx = tbl;
        res_nx = res_stat;
        if (wr_any) res_nx[tbl[wr_idx].dst] = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (tbl[u].state == ST_OPWAIT && wr_any) begin
                if (tbl[u].prod_a.vld && (tbl[u].prod_a.idx == wr_idx)) begin
                    tbl_nx[u].rdy_a  = 1'b1;
                    tbl_nx[u].prod_a = '0;
                end
                if (tbl[u].prod_b.vld && (tbl[u].prod_b.idx == wr_idx)) begin
                    tbl_nx[u].rdy_b  = 1'b1;
                    tbl_nx[u].prod_b = '0;
                end
            end
            if (read_grant[u]) begin
                tbl_nx[u].state = ST_EXEC;
                tbl_nx[u].rdy_a = 1'b0;
                tbl_nx[u].rdy_b = 1'b0;
            end
            if (tbl[u].state == ST_EXEC && done_pulse[u]) begin
                tbl_nx[u].state = ST_DONE;
            end
            if (write_grant[u]) begin
                tbl_nx[u] = '0;
            end
            if (issue_unit[u]) begin
                tbl_nx[u].state  = ST_OPWAIT;
                tbl_nx[u].kind   = fu_kind_e'(in_kind);
                tbl_nx[u].dst    = in_dst;
                tbl_nx[u].src_a  = in_src_a;
                tbl_nx[u].src_b  = in_src_b;
                tbl_nx[u].prod_a = new_pa;
                tbl_nx[u].prod_b = new_pb;
                tbl_nx[u].rdy_a  = !new_pa.vld;
                tbl_nx[u].rdy_b  = !new_pb.vld;
            end
        end
        if (issue_fire) begin
            res_nx[in_dst].vld = 1'b1;
            res_nx[in_dst].idx = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl      <= '0;
            res_stat <= '0;
        end else begin
            tbl      <= tbl_nx;
            res_stat <= res_nx;
        end
    end

    for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
        // R3: an accepted instruction never shares a destination with a busy unit.
        p_no_dup_dst_r3: assert property (@(posedge clk) disable iff (rst)
            (issue_fire && tbl[u].state != ST_IDLE) |-> (tbl[u].dst != in_dst));

        // R4: only an idle unit is handed a new instruction.
        p_issue_idle_r4: assert property (@(posedge clk) disable iff (rst)
            issue_unit[u] |-> (tbl[u].state == ST_IDLE));

        // R5: no operand read while a producer tag is still outstanding.
        p_read_no_pending_r5: assert property (@(posedge clk) disable iff (rst)
            read_grant[u] |-> (!tbl[u].prod_a.vld && !tbl[u].prod_b.vld));

        p_exec_after_read_r5: assert property (@(posedge clk) disable iff (rst)
            read_grant[u] |=> (tbl[u].state == ST_EXEC));

        // R7: a waiting unit leaves that state only through a read grant.
        p_done_ignored_r7: assert property (@(posedge clk) disable iff (rst)
            (tbl[u].state == ST_OPWAIT && !read_grant[u]) |=> (tbl[u].state == ST_OPWAIT));

        // R10: the written unit is free on the next cycle.
        p_freed_after_write_r10: assert property (@(posedge clk) disable iff (rst)
            write_grant[u] |=> (tbl[u].state == ST_IDLE));
    end

endmodule

// File: tb/tb_scoreboard_ctl.sv
module tb_scoreboard_ctl;
    import sb_pkg::*;

    timeunit 1ns;
    timeprecision 1ps;

    localparam int NF = NUM_FU;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [1:0]        in_kind = '0;
    logic [REG_W-1:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic              in_ready;
    logic [NF-1:0]     issue_unit, done_pulse = '0, read_grant, write_grant;

    always #2.5 clk = ~clk;

    scoreboard_ctl dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_kind     (in_kind),
        .in_dst      (in_dst),
        .in_src_a    (in_src_a),
        .in_src_b    (in_src_b),
        .in_ready    (in_ready),
        .issue_unit  (issue_unit),
        .done_pulse  (done_pulse),
        .read_grant  (read_grant),
        .write_grant (write_grant)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench view of each unit, built only from port activity.
    bit            m_busy [NF];
    bit            m_read [NF];
    bit            m_exec [NF];
    bit            m_done [NF];
    int            m_dst  [NF];
    int            m_sa   [NF];
    int            m_sb   [NF];
    int            m_seq  [NF];
    logic [NF-1:0] m_wait [NF];
    int            seq_ctr = 0;

    function automatic int kind_of(int u);
        if (u == 0) return 0;
        if (u <= 2) return 1;
        if (u == 3) return 2;
        return 3;
    endfunction

    function automatic logic [NF-1:0] lowest(logic [NF-1:0] v);
        return v & (~v + NF'(1));
    endfunction

    task automatic check(string tag, logic [NF-1:0] act, logic [NF-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit v, int k, int d, int a, int b, logic [NF-1:0] dn);
        logic [NF-1:0] e_rd, e_wr, e_iss, freek, wm;
        bit            e_rdy, dst_busy, blk;
        @(posedge clk);
        #1;
        in_valid   = v;
        in_kind    = k[1:0];
        in_dst     = d[REG_W-1:0];
        in_src_a   = a[REG_W-1:0];
        in_src_b   = b[REG_W-1:0];
        done_pulse = dn;
        e_rd = '0; e_wr = '0; freek = '0; dst_busy = 0;
        for (int u = 0; u < NF; u++) begin
            if (m_busy[u] && !m_read[u] && m_wait[u] == '0) e_rd[u] = 1'b1;
            if (m_done[u]) begin
                blk = 0;
                for (int w = 0; w < NF; w++) begin
                    if (w != u && m_busy[w] && !m_read[w] && m_seq[w] < m_seq[u] &&
                        (m_sa[w] == m_dst[u] || m_sb[w] == m_dst[u])) blk = 1;
                end
                if (!blk) e_wr[u] = 1'b1;
            end
            if (!m_busy[u] && kind_of(u) == k) freek[u] = 1'b1;
            if (m_busy[u] && m_dst[u] == d) dst_busy = 1;
        end
        e_rd  = lowest(e_rd);
        e_wr  = lowest(e_wr);
        e_rdy = (freek != '0) && !dst_busy;
        e_iss = (v && e_rdy) ? lowest(freek) : '0;
        @(negedge clk);
        check("R2/R3 in_ready", NF'(in_ready), NF'(e_rdy));
        check("R4 issue_unit", issue_unit, e_iss);
        check("R5/R6 read_grant", read_grant, e_rd);
        check("R8/R9 write_grant", write_grant, e_wr);
        // Advance the bench view by what this cycle's edge does.
        wm = '0;
        if (e_iss != '0) begin
            for (int u = 0; u < NF; u++)
                if (m_busy[u] && !e_wr[u] && (m_dst[u] == a || m_dst[u] == b)) wm[u] = 1'b1;
        end
        for (int u = 0; u < NF; u++) begin
            if (e_wr[u]) begin      // R10: unit and destination released
                m_busy[u] = 0; m_read[u] = 0; m_exec[u] = 0; m_done[u] = 0;
            end
            m_wait[u] = m_wait[u] & ~e_wr;
        end
        for (int u = 0; u < NF; u++) begin
            if (e_rd[u]) begin
                m_read[u] = 1; m_exec[u] = 1;
            end else if (m_exec[u] && dn[u]) begin   // R7: only an executing unit completes
                m_exec[u] = 0; m_done[u] = 1;
            end
            if (e_iss[u]) begin
                m_busy[u] = 1; m_read[u] = 0; m_exec[u] = 0; m_done[u] = 0;
                m_dst[u] = d; m_sa[u] = a; m_sb[u] = b;
                m_seq[u] = seq_ctr; m_wait[u] = wm;
                seq_ctr++;
            end
        end
    endtask

    task automatic idle(int n, logic [NF-1:0] dn);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, dn);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < NF; u++) begin
            m_busy[u] = 0; m_read[u] = 0; m_exec[u] = 0; m_done[u] = 0;
            m_dst[u] = 0; m_sa[u] = 0; m_sb[u] = 0; m_seq[u] = 0; m_wait[u] = '0;
        end
        void'($urandom(32'h5eed_0b0e));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports.
        check("R1 in_ready", NF'(in_ready), NF'(1'b1));
        check("R1 read_grant", read_grant, '0);
        check("R1 write_grant", write_grant, '0);
        check("R1 issue_unit", issue_unit, '0);

        // R8: divide feeds add; integer op overwrites a source of the add.
        step(1, 3, 0, 2, 4, '0);        // divide r0 <- r2,r4
        step(1, 2, 10, 0, 8, '0);       // add r10 <- r0,r8 (waits on divide)
        step(1, 0, 8, 8, 14, '0);       // integer r8 <- r8,r14
        idle(2, 5'b00001);              // integer completes, write held by the add
        idle(2, 5'b00000);
        idle(1, 5'b10000);              // divide completes
        idle(4, 5'b01000);              // add completes; integer write follows the add's read
        idle(4, '0);

        // R2: two multipliers then a third stalls; R3: repeated destination stalls.
        step(1, 1, 3, 1, 1, '0);
        step(1, 1, 4, 1, 1, '0);
        step(1, 1, 5, 1, 1, '0);
        step(1, 0, 3, 6, 6, '0);
        // R7: completion pulses to idle units and units not yet read are ignored.
        step(0, 0, 0, 0, 0, 5'b11001);
        idle(3, 5'b00110);
        step(1, 0, 3, 6, 6, '0);        // R10: destination free once written
        idle(6, 5'b00001);

        // R5: producer write and consumer read fall in consecutive cycles.
        step(1, 2, 12, 1, 1, '0);
        step(1, 0, 13, 12, 12, '0);
        idle(2, '0);
        idle(1, 5'b01000);
        idle(4, 5'b00001);

        // Random mix over a narrow register range (R2..R10).
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(9, 0) < 7, $urandom_range(3, 0), $urandom_range(7, 0),
                 $urandom_range(7, 0), $urandom_range(7, 0), NF'($urandom));
        end
        idle(40, '1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule